// File: doc/BRIEF.md
# Preset-Selected Clock Output Pair Controller

This block drives one output pair of a multi-output clock generator. A source tick (the rising edge of the PLL clock, seen as a one-cycle strobe) or, in bypass, a reference tick feeds two programmable integer dividers. Each of the two outputs toggles on the terminal strobe of the divider that its route field picks. The route can also pick a strobe that a neighbouring channel supplies. Each output is therefore a 50 % duty square wave whose half period is N source ticks.

A 3-bit preset index from external select pins picks one bit of an 8-bit per-pair selection vector. That bit chooses between two stored 2-bit state codes, which decide whether the pair runs, parks low, parks in tristate, or powers the PLL down. A global power-down input overrides all presets, and the configuration input is left untouched. An output that is disabled gracefully first finishes its high phase and then parks low. An output that is re-enabled starts from low, so its first phase is a full high phase.

Each output has a gate state machine with three states:
- GS_RUN: the output toggles on each strobe.
- GS_DRAIN: a stop is pending and the output waits for the falling strobe.
- GS_PARK: the output is held low or in tristate.

Its transitions are:
- start: GS_PARK to GS_RUN.
- soft stop at low: GS_RUN to GS_PARK.
- soft stop at high: GS_RUN to GS_DRAIN.
- drain done: GS_DRAIN to GS_PARK on a strobe.
- drain cancel: GS_DRAIN to GS_RUN.
- forced off: any state to GS_PARK at once.

Each divider has two states:
- DV_IDLE: standby while the ratio is 0.
- DV_COUNT: counting.

Its transitions are load (DV_IDLE to DV_COUNT on a tick with a non-zero ratio) and clear (any state to DV_IDLE when the ratio is 0).

Top module: `clkout_ctl`

## Requirements
- R1: The effective pair code is cfg[11:10] when bit cfg[preset_i] of the selection vector cfg[7:0] is 1, and cfg[9:8] when that bit is 0.
- R2: With code 11 each output toggles once per terminal strobe of its routed divider, so a ratio of N gives a half period of N source ticks, and out_*_en_o is 1.
- R3: Code 00 forces both outputs low and tristated and raises pll_pd_o on the next clock edge, without waiting for a low phase.
- R4: Code 01 (park in tristate) or 10 (park low) lets a high output stay high until its next strobe, then holds it low. out_*_z_o is 1 only in the parked state under code 01 or 00, and out_*_en_o drops to 0.
- R5: After re-enable an output starts low, and its first change is a rise at the next strobe, which gives a full high phase.
- R6: While pwr_down_i is 1, both outputs are low and tristated and pll_pd_o is 1 from the next edge on. After release, operation resumes from the unchanged cfg_i.
- R7: A divider ratio of 0 (div A at cfg[16+:DIV_A_W], div B above it) holds that divider in standby with no strobes, so a routed output does not toggle.
- R8: A new non-zero ratio takes effect only after the current count reaches its terminal strobe.
- R9: Route A (cfg[13]): 0 selects divider A, 1 selects nbr_tick_i.
- R10: Route B (cfg[15:14]): 00 selects nbr_tick_i, 01 selects divider A, 10 selects divider B, and the reserved code 11 also selects divider B.
- R11: Bypass (cfg[12]=1) clocks both dividers from ref_tick_i instead of pll_tick_i and raises pll_pd_o on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 16+DIV_A_W+DIV_B_W | Flat configuration vector |
| preset_i | input | 3 | Preset index from select pins |
| pwr_down_i | input | 1 | Global power-down |
| pll_tick_i | input | 1 | PLL clock rising-edge strobe |
| ref_tick_i | input | 1 | Reference clock rising-edge strobe |
| nbr_tick_i | input | 1 | Neighbour channel divider strobe |
| out_a_o | output | 1 | First output clock level |
| out_b_o | output | 1 | Second output clock level |
| out_a_en_o | output | 1 | First output running |
| out_b_en_o | output | 1 | Second output running |
| out_a_z_o | output | 1 | First output tristated |
| out_b_z_o | output | 1 | Second output tristated |
| pll_pd_o | output | 1 | PLL power-down indication |

## Verification
Every result is due one edge after the inputs that cause it: a tick strobe, a code change or power-down shows on the outputs at the first rising edge at which it is sampled. A graceful stop completes only at the first strobe after the request, and a ratio change only at the terminal strobe of the running count. The bench drives inputs on the falling edge, advances its behavioural model at the rising edge from those same inputs, and compares all seven outputs on the following falling edge. This keeps every comparison exactly one edge behind its cause. Directed counts of toggles over fixed windows confirm the division ratios independently of the model.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    localparam int PRESETS  = 8;
    localparam int PRESET_W = $clog2(PRESETS);

    // 2-bit pair state code held in the two stored definitions
    typedef enum logic [1:0] {
        CODE_OFF = 2'b00,
        CODE_HIZ = 2'b01,
        CODE_LOW = 2'b10,
        CODE_RUN = 2'b11
    } out_code_e;

    // route codes for the second output of the pair
    typedef enum logic [1:0] {
        RB_NBR = 2'b00,
        RB_A   = 2'b01,
        RB_B   = 2'b10,
        RB_RSV = 2'b11
    } route_b_e;

    typedef enum logic [1:0] {
        GS_RUN   = 2'b00,
        GS_DRAIN = 2'b01,
        GS_PARK  = 2'b10
    } gate_state_e;

    typedef enum logic {
        DV_IDLE  = 1'b0,
        DV_COUNT = 1'b1
    } div_state_e;

endpackage

// File: rtl/tick_divider.sv
module tick_divider
    import clkout_pkg::*;
#(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio_i,
    input  logic         tick_i,
    output logic         strobe_o
);

    div_state_e   st_q, st_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] cur_q, cur_d;
    logic         ratio_zero;
    logic         at_end;

    assign ratio_zero = (ratio_i == '0);
    assign at_end     = (cnt_q == cur_q - W'(1));

    // next-state process
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        cur_d = cur_q;
        if (ratio_zero) begin
            st_d  = DV_IDLE;
            cnt_d = '0;
            cur_d = '0;
        end else if (tick_i) begin
            unique case (st_q)
                DV_IDLE: begin
                    st_d  = DV_COUNT;
                    cur_d = ratio_i;
                    cnt_d = '0;
                end
                DV_COUNT: begin
                    if (at_end) begin
                        cnt_d = '0;
                        cur_d = ratio_i;
                    end else begin
                        cnt_d = cnt_q + W'(1);
                    end
                end
                default: st_d = DV_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DV_IDLE;
            cnt_q <= '0;
            cur_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            cur_q <= cur_d;
        end
    end

    // output: terminal strobe of the running count
    always_comb begin
        strobe_o = tick_i && !ratio_zero && (st_q == DV_COUNT) && at_end;
    end

endmodule

// File: rtl/preset_decode.sv
module preset_decode
    import clkout_pkg::*;
(
    input  logic [PRESETS-1:0]  sel_vec_i,
    input  logic [PRESET_W-1:0] preset_i,
    input  logic [1:0]          code0_i,
    input  logic [1:0]          code1_i,
    output out_code_e           code_o
);

    logic pick;

    always_comb begin
        pick   = sel_vec_i[preset_i];
        code_o = out_code_e'(pick ? code1_i : code0_i);
    end

endmodule

// File: rtl/tick_route.sv
module tick_route
    import clkout_pkg::*;
(
    input  logic     div_a_i,
    input  logic     div_b_i,
    input  logic     nbr_i,
    input  logic     route_a_i,
    input  route_b_e route_b_i,
    output logic     str_a_o,
    output logic     str_b_o
);

    always_comb begin
        str_a_o = route_a_i ? nbr_i : div_a_i;
        unique case (route_b_i)
            RB_NBR:  str_b_o = nbr_i;
            RB_A:    str_b_o = div_a_i;
            RB_B:    str_b_o = div_b_i;
            RB_RSV:  str_b_o = div_b_i;
            default: str_b_o = div_b_i;
        endcase
    end

endmodule

// File: rtl/out_gate.sv
module out_gate
    import clkout_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strobe_i,
    input  logic      force_off_i,
    input  out_code_e code_i,
    output logic      lvl_o,
    output logic      en_o,
    output logic      z_o
);

    gate_state_e st_q, st_d;
    logic        lvl_d;
    logic        kill;
    logic        want_run;
    logic        tri_tgt;

    assign kill     = force_off_i || (code_i == CODE_OFF);
    assign want_run = !kill && (code_i == CODE_RUN);
    assign tri_tgt  = kill || (code_i == CODE_HIZ);

    // next-state process
    always_comb begin
        st_d  = st_q;
        lvl_d = lvl_o;
        if (kill) begin
            st_d  = GS_PARK;
            lvl_d = 1'b0;
        end else begin
            unique case (st_q)
                GS_RUN: begin
                    if (want_run) begin
                        if (strobe_i) lvl_d = ~lvl_o;
                    end else if (!lvl_o) begin
                        st_d = GS_PARK;
                    end else if (strobe_i) begin
                        lvl_d = 1'b0;
                        st_d  = GS_PARK;
                    end else begin
                        st_d = GS_DRAIN;
                    end
                end
                GS_DRAIN: begin
                    if (want_run) begin
                        st_d = GS_RUN;
                        if (strobe_i) lvl_d = ~lvl_o;
                    end else if (strobe_i) begin
                        lvl_d = 1'b0;
                        st_d  = GS_PARK;
                    end
                end
                GS_PARK: begin
                    if (want_run) st_d = GS_RUN;
                end
                default: begin
                    st_d  = GS_PARK;
                    lvl_d = 1'b0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GS_PARK;
        else        st_q <= st_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_o <= 1'b0;
            en_o  <= 1'b0;
            z_o   <= 1'b1;
        end else begin
            lvl_o <= lvl_d;
            en_o  <= (st_d == GS_RUN);
            z_o   <= (st_d == GS_PARK) && tri_tgt;
        end
    end

endmodule

// File: rtl/clkout_ctl.sv
module clkout_ctl
    import clkout_pkg::*;
#(
    parameter int DIV_A_W = 7,
    parameter int DIV_B_W = 7,
    localparam int CFG_W  = 16 + DIV_A_W + DIV_B_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CFG_W-1:0]    cfg_i,
    input  logic [PRESET_W-1:0] preset_i,
    input  logic                pwr_down_i,
    input  logic                pll_tick_i,
    input  logic                ref_tick_i,
    input  logic                nbr_tick_i,
    output logic                out_a_o,
    output logic                out_b_o,
    output logic                out_a_en_o,
    output logic                out_b_en_o,
    output logic                out_a_z_o,
    output logic                out_b_z_o,
    output logic                pll_pd_o
);

    localparam int SEL_LSB  = 0;
    localparam int C0_LSB   = SEL_LSB + PRESETS;
    localparam int C1_LSB   = C0_LSB + 2;
    localparam int BYP_BIT  = C1_LSB + 2;
    localparam int RA_BIT   = BYP_BIT + 1;
    localparam int RB_LSB   = RA_BIT + 1;
    localparam int DA_LSB   = RB_LSB + 2;
    localparam int DB_LSB   = DA_LSB + DIV_A_W;
    localparam int N_OUT    = 2;

    logic               bypass;
    logic               src_tick;
    logic               str_div_a, str_div_b;
    logic               str_a, str_b;
    out_code_e          pair_code;
    logic [N_OUT-1:0]   strobe_v, lvl_v, en_v, z_v;

    assign bypass   = cfg_i[BYP_BIT];
    assign src_tick = bypass ? ref_tick_i : pll_tick_i;

    preset_decode u_dec (
        .sel_vec_i (cfg_i[SEL_LSB +: PRESETS]),
        .preset_i  (preset_i),
        .code0_i   (cfg_i[C0_LSB +: 2]),
        .code1_i   (cfg_i[C1_LSB +: 2]),
        .code_o    (pair_code)
    );

    tick_divider #(.W(DIV_A_W)) u_div_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio_i  (cfg_i[DA_LSB +: DIV_A_W]),
        .tick_i   (src_tick),
        .strobe_o (str_div_a)
    );

    tick_divider #(.W(DIV_B_W)) u_div_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio_i  (cfg_i[DB_LSB +: DIV_B_W]),
        .tick_i   (src_tick),
        .strobe_o (str_div_b)
    );

    tick_route u_route (
        .div_a_i   (str_div_a),
        .div_b_i   (str_div_b),
        .nbr_i     (nbr_tick_i),
        .route_a_i (cfg_i[RA_BIT]),
        .route_b_i (route_b_e'(cfg_i[RB_LSB +: 2])),
        .str_a_o   (str_a),
        .str_b_o   (str_b)
    );

    assign strobe_v = {str_b, str_a};

    for (genvar g = 0; g < N_OUT; g++) begin : g_gate
        out_gate u_gate (
            .clk         (clk),
            .rst_n       (rst_n),
            .strobe_i    (strobe_v[g]),
            .force_off_i (pwr_down_i),
            .code_i      (pair_code),
            .lvl_o       (lvl_v[g]),
            .en_o        (en_v[g]),
            .z_o         (z_v[g])
        );
    end

    assign out_a_o    = lvl_v[0];
    assign out_b_o    = lvl_v[1];
    assign out_a_en_o = en_v[0];
    assign out_b_en_o = en_v[1];
    assign out_a_z_o  = z_v[0];
    assign out_b_z_o  = z_v[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pll_pd_o <= 1'b1;
        else        pll_pd_o <= pwr_down_i || bypass || (pair_code == CODE_OFF);
    end

endmodule

// File: rtl/clkout_ctl_chk.sv
module clkout_ctl_chk #(
    parameter int DIV_A_W = 7,
    parameter int DIV_B_W = 7,
    localparam int CFG_W  = 16 + DIV_A_W + DIV_B_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_i,
    input logic [2:0]       preset_i,
    input logic             pwr_down_i,
    input logic             out_a_o,
    input logic             out_b_o,
    input logic             out_a_en_o,
    input logic             out_b_en_o,
    input logic             out_a_z_o,
    input logic             out_b_z_o,
    input logic             pll_pd_o
);

    logic [1:0] eff_code;
    logic       div_a_zero, div_b_zero;

    assign eff_code   = cfg_i[preset_i] ? cfg_i[11:10] : cfg_i[9:8];
    assign div_a_zero = (cfg_i[16 +: DIV_A_W] == '0);
    assign div_b_zero = (cfg_i[16 + DIV_A_W +: DIV_B_W] == '0);

    AST_PD_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_i |=> (out_a_z_o && out_b_z_o && pll_pd_o && !out_a_o && !out_b_o)); // R6

    AST_OFF_CODE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_code == 2'b00) |=> (pll_pd_o && out_a_z_o && out_b_z_o)); // R3

    AST_BYPASS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i[12] |=> pll_pd_o); // R11

    AST_Z_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_a_z_o |-> !out_a_o) and (out_b_z_o |-> !out_b_o)); // R4

    AST_Z_EXCL_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_a_z_o && out_a_en_o) && !(out_b_z_o && out_b_en_o)); // R4

    AST_RISE_WHEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_a_o) |-> $past(out_a_en_o)); // R5

    AST_STANDBY_A: assert property (@(posedge clk) disable iff (!rst_n)
        (div_a_zero && !cfg_i[13]) |=> (!out_a_o || $stable(out_a_o))); // R7

    AST_STANDBY_B: assert property (@(posedge clk) disable iff (!rst_n)
        (div_b_zero && cfg_i[15:14] == 2'b10) |=> (!out_b_o || $stable(out_b_o))); // R7

endmodule

bind clkout_ctl clkout_ctl_chk #(.DIV_A_W(DIV_A_W), .DIV_B_W(DIV_B_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_i      (cfg_i),
    .preset_i   (preset_i),
    .pwr_down_i (pwr_down_i),
    .out_a_o    (out_a_o),
    .out_b_o    (out_b_o),
    .out_a_en_o (out_a_en_o),
    .out_b_en_o (out_b_en_o),
    .out_a_z_o  (out_a_z_o),
    .out_b_z_o  (out_b_z_o),
    .pll_pd_o   (pll_pd_o)
);

// File: tb/clkout_ctl_tb_top.sv
module clkout_ctl_tb_top;

    localparam int DAW   = 7;
    localparam int DBW   = 7;
    localparam int CFGW  = 16 + DAW + DBW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CFGW-1:0] cfg_i = '0;
    logic [2:0]      preset_i = 3'd0;
    logic            pwr_down_i = 1'b0;
    logic            pll_tick_i = 1'b0;
    logic            ref_tick_i = 1'b0;
    logic            nbr_tick_i = 1'b0;
    logic            out_a_o, out_b_o, out_a_en_o, out_b_en_o;
    logic            out_a_z_o, out_b_z_o, pll_pd_o;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    int    pll_per = 1;
    bit    started = 0;
    bit    finished = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    clkout_ctl #(.DIV_A_W(DAW), .DIV_B_W(DBW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .preset_i(preset_i),
        .pwr_down_i(pwr_down_i), .pll_tick_i(pll_tick_i), .ref_tick_i(ref_tick_i),
        .nbr_tick_i(nbr_tick_i), .out_a_o(out_a_o), .out_b_o(out_b_o),
        .out_a_en_o(out_a_en_o), .out_b_en_o(out_b_en_o),
        .out_a_z_o(out_a_z_o), .out_b_z_o(out_b_z_o), .pll_pd_o(pll_pd_o)
    );

    function automatic logic [CFGW-1:0] mk_cfg(input logic [7:0] sel, input logic [1:0] c0,
        input logic [1:0] c1, input logic byp, input logic ra, input logic [1:0] rb,
        input int da, input int db);
        logic [CFGW-1:0] v;
        v = '0;
        v[7:0] = sel; v[9:8] = c0; v[11:10] = c1; v[12] = byp; v[13] = ra;
        v[15:14] = rb; v[16 +: DAW] = DAW'(da); v[16+DAW +: DBW] = DBW'(db);
        return v;
    endfunction

    // tick generators on the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        pll_tick_i = (cyc % pll_per) == 0;
        ref_tick_i = (cyc % 3) == 0;
        nbr_tick_i = (cyc % 5) == 0;
    end

    // behavioural reference model: 0 run, 1 draining, 2 parked
    int m_cur[2], m_cnt[2], m_st[2];
    bit m_lvl[2], m_en[2], m_z[2];
    bit m_pd;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_cur[i] = 0; m_cnt[i] = 0; m_st[i] = 2;
                m_lvl[i] = 0; m_en[i] = 0; m_z[i] = 1;
            end
            m_pd = 1;
        end else begin
            bit src, byp, kill, run, tri_t;
            bit dstr[2];
            bit ostr[2];
            int code;
            byp = cfg_i[12];
            src = byp ? ref_tick_i : pll_tick_i;
            for (int d = 0; d < 2; d++) begin
                int ratio;
                ratio = (d == 0) ? int'(cfg_i[16 +: DAW]) : int'(cfg_i[16+DAW +: DBW]);
                dstr[d] = 0;
                if (ratio == 0) begin
                    m_cur[d] = 0; m_cnt[d] = 0;
                end else if (src) begin
                    if (m_cur[d] == 0) begin
                        m_cur[d] = ratio; m_cnt[d] = 0;
                    end else if (m_cnt[d] == m_cur[d] - 1) begin
                        dstr[d] = 1; m_cnt[d] = 0; m_cur[d] = ratio;
                    end else begin
                        m_cnt[d]++;
                    end
                end
            end
            ostr[0] = cfg_i[13] ? nbr_tick_i : dstr[0];
            case (cfg_i[15:14])
                2'b00:   ostr[1] = nbr_tick_i;
                2'b01:   ostr[1] = dstr[0];
                default: ostr[1] = dstr[1];
            endcase
            code  = cfg_i[preset_i] ? int'(cfg_i[11:10]) : int'(cfg_i[9:8]);
            kill  = pwr_down_i || code == 0;
            run   = !kill && code == 3;
            tri_t = kill || code == 1;
            for (int o = 0; o < 2; o++) begin
                if (kill) begin
                    m_st[o] = 2; m_lvl[o] = 0;
                end else if (run) begin
                    if (m_st[o] != 2 && ostr[o]) m_lvl[o] = !m_lvl[o];
                    m_st[o] = 0;
                end else if (m_st[o] != 2) begin
                    if (!m_lvl[o]) m_st[o] = 2;
                    else if (ostr[o]) begin m_lvl[o] = 0; m_st[o] = 2; end
                    else m_st[o] = 1;
                end
                m_en[o] = (m_st[o] == 0);
                m_z[o]  = (m_st[o] == 2) && tri_t;
            end
            m_pd = pwr_down_i || byp || code == 0;
        end
        started = 1;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !finished) begin
            check(cur_req, {out_a_o, out_b_o, out_a_en_o, out_b_en_o, out_a_z_o, out_b_z_o, pll_pd_o},
                  {m_lvl[0], m_lvl[1], m_en[0], m_en[1], m_z[0], m_z[1], m_pd});
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_tog(input int n, output int ta, output int tb);
        logic pa, pb;
        ta = 0; tb = 0;
        @(negedge clk);
        pa = out_a_o; pb = out_b_o;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (out_a_o != pa) ta++;
            if (out_b_o != pb) tb++;
            pa = out_a_o; pb = out_b_o;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        int ta, tb;
        cfg_i = mk_cfg(8'h02, 2'b01, 2'b11, 0, 0, 2'b10, 3, 2);
        step(3);
        cur_req = "R4";
        check("R4 reset z", out_a_z_o, 1);
        check("R4 reset pd", pll_pd_o, 1);
        rst_n = 1'b1;
        step(4);
        cur_req = "R1";
        check("R1 preset0 parked hiz", out_a_z_o, 1);
        preset_i = 3'd1;
        step(20);
        cur_req = "R2";
        count_tog(60, ta, tb);
        check("R2 div3 toggles", ta, 20);
        check("R2 div2 toggles", tb, 30);
        check("R2 enabled", out_a_en_o, 1);
        cur_req = "R4";
        cfg_i = mk_cfg(8'h02, 2'b10, 2'b11, 0, 0, 2'b10, 3, 2);
        preset_i = 3'd0;
        step(10);
        check("R4 park low level", out_a_o, 0);
        check("R4 park low z", out_a_z_o, 0);
        check("R4 park low en", out_a_en_o, 0);
        cfg_i = mk_cfg(8'h02, 2'b01, 2'b11, 0, 0, 2'b10, 3, 2);
        step(3);
        check("R4 park hiz z", out_b_z_o, 1);
        cur_req = "R5";
        preset_i = 3'd1;
        step(12);
        cur_req = "R3";
        cfg_i = mk_cfg(8'h02, 2'b01, 2'b00, 0, 0, 2'b10, 3, 2);
        step(1);
        check("R3 off pd", pll_pd_o, 1);
        check("R3 off z", out_a_z_o & out_b_z_o, 1);
        cfg_i = mk_cfg(8'h02, 2'b01, 2'b11, 0, 0, 2'b10, 3, 2);
        step(10);
        cur_req = "R6";
        pwr_down_i = 1'b1;
        step(1);
        check("R6 pd z", out_a_z_o & out_b_z_o, 1);
        check("R6 pd pll", pll_pd_o, 1);
        step(5);
        pwr_down_i = 1'b0;
        step(15);
        check("R6 resumed", out_a_en_o, 1);
        cur_req = "R7";
        cfg_i = mk_cfg(8'h02, 2'b01, 2'b11, 0, 0, 2'b10, 0, 2);
        step(2);
        count_tog(20, ta, tb);
        check("R7 standby no toggles", ta, 0);
        cur_req = "R8";
        cfg_i = mk_cfg(8'h02, 2'b01, 2'b11, 0, 0, 2'b10, 4, 2);
        step(6);
        cfg_i = mk_cfg(8'h02, 2'b01, 2'b11, 0, 0, 2'b10, 2, 5);
        step(25);
        cur_req = "R9";
        cfg_i = mk_cfg(8'h02, 2'b01, 2'b11, 0, 1, 2'b10, 2, 5);
        step(5);
        count_tog(50, ta, tb);
        check("R9 nbr toggles", ta, 10);
        cur_req = "R10";
        cfg_i = mk_cfg(8'h02, 2'b01, 2'b11, 0, 0, 2'b00, 2, 5);
        step(20);
        cfg_i = mk_cfg(8'h02, 2'b01, 2'b11, 0, 0, 2'b01, 2, 5);
        step(20);
        cfg_i = mk_cfg(8'h02, 2'b01, 2'b11, 0, 0, 2'b11, 2, 3);
        step(10);
        count_tog(60, ta, tb);
        check("R10 reserved uses div B", tb, 20);
        cur_req = "R11";
        cfg_i = mk_cfg(8'h02, 2'b01, 2'b11, 1, 0, 2'b10, 1, 2);
        step(2);
        check("R11 bypass pd", pll_pd_o, 1);
        count_tog(60, ta, tb);
        check("R11 ref tick toggles", ta, 20);
        cur_req = "R2";
        pll_per = 2;
        cfg_i = mk_cfg(8'h02, 2'b01, 2'b11, 0, 0, 2'b10, 3, 1);
        step(40);
        cur_req = "R1";
        cfg_i = mk_cfg(8'hA5, 2'b10, 2'b11, 0, 0, 2'b10, 2, 3);
        for (int p = 0; p < 8; p++) begin
            preset_i = 3'(p);
            step(14);
            check("R1 preset sweep en", out_a_en_o, ((8'hA5 >> p) & 1));
        end
        step(5);
        finish_run();
    end

endmodule